// File: doc/BRIEF.md
# Multiprocessor Startup IPI Sequencer

This block turns a 64-bit interprocessor command word into delivery actions for a small system of `NPROC` processors. Fixed-vector interrupts and non-maskable interrupts are fanned out to a target set. The set is chosen by a two-bit destination shorthand: one explicit processor, the sender itself, every active processor, or every active processor except the sender. All targets in the set receive their strobe in the same cycle, one clock after the send strobe.

The block also tracks a boot state for each processor. Processor 0 is the bootstrap processor and comes out of reset running. Every other processor starts held in reset. An asserted INIT command from processor 0 moves a held processor into a waiting-for-startup state. A startup command from processor 0 then releases it. The release is reported as a startup request that carries the target index and a page-aligned start address taken from the vector. The released processor joins the active set. Commands that this block cannot complete by itself raise a one-cycle unhandled flag, and higher-level logic deals with them.

In legacy addressing mode the command arrives in two halves. A write of the high half only stores it. The send then takes the low half from the command input and combines it with the stored high half. In extended addressing mode the whole 64-bit word is taken at once.

Top module: `ipi_startup_seq`

## Requirements
- R1: After reset all outputs are zero, processor 0 is running, every other processor is held in reset, and the active set used for fan-out is the `active_mask` input ORed with the processors that are running.
- R2: Field positions in the 64-bit command: vector [7:0], delivery mode [10:8] (000 fixed, 100 NMI, 101 INIT, 110 startup), level [14] (0 = deassert), shorthand [19:18] (00 explicit, 01 self, 10 all including self, 11 all excluding self). The destination is [63:56] in legacy mode and [63:32] in extended mode.
- R3: In legacy mode, `hi_wr` stores `cmd_word[63:32]` as the high half and causes no output. A send ignores `cmd_word[63:32]` and uses the stored half. In extended mode `hi_wr` is ignored and the send uses `cmd_word[63:32]`.
- R4: A fixed-mode send drives `intr_stb` to the target set and `intr_vec` to the vector one cycle later, with `nmi_stb` zero.
- R5: An NMI-mode send drives `nmi_stb` to the target set one cycle later, with `intr_stb` zero.
- R6: Target sets: explicit gives the single destination if it is below `NPROC`, otherwise an empty set; self gives the sender; all-including gives the active set; all-excluding gives the active set without the sender.
- R7: An INIT command with level 0 is ignored. It produces no output, no unhandled flag and no state change.
- R8: An asserted INIT from sender 0 to a destination that is nonzero and below `NPROC` moves the target from held to waiting. A target in any other state is left unchanged.
- R9: A startup from sender 0 to a nonzero destination below `NPROC` that is waiting produces, one cycle later, `start_vld` with `start_tgt` set to the destination and `start_addr` set to the vector shifted left by 12. The target becomes running and active. If the target is in any other state the command is ignored and `unhandled` stays low.
- R10: `unhandled` pulses one cycle after a send that has another delivery mode, or that is an asserted INIT or a startup whose sender is not 0 or whose destination is 0 or not below `NPROC`.
- R11: All outputs are single-cycle pulses that appear only one cycle after a send. Each send produces at most one kind of output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_word | input | 64 | Command word (high half used only in extended mode or on `hi_wr`) |
| send | input | 1 | Issue the command |
| hi_wr | input | 1 | Store the high half (legacy mode only) |
| sender | input | IDXW | Index of the issuing processor |
| x2_mode | input | 1 | 1 = extended 32-bit destination addressing |
| active_mask | input | NPROC | Processors already active outside this block |
| intr_stb | output | NPROC | Fixed-vector interrupt strobe per target |
| intr_vec | output | 8 | Vector of the fixed interrupt |
| nmi_stb | output | NPROC | NMI strobe per target |
| start_vld | output | 1 | Startup request valid |
| start_tgt | output | IDXW | Startup target index |
| start_addr | output | 20 | Startup address (vector << 12) |
| unhandled | output | 1 | Command not completed by this block |

## Verification
The assertions assume that `send` and `hi_wr` are never raised in the same cycle, and that `sender` is below `NPROC` whenever `send` is high. Under those assumptions the self-target and exclusion properties compare the strobes against a single bit position. The stimulus drives one command at a time on the falling edge, always uses sender indices inside the system, and returns both strobes to zero between commands.

// File: rtl/ipi_seq_pkg.sv
// Package: shared field positions, mode codes and boot-state type for the
// IPI sequencer. Assumes a 64-bit command word with the layout in the brief.
package ipi_seq_pkg;

    localparam int VEC_LSB   = 0;
    localparam int MODE_LSB  = 8;
    localparam int LEVEL_BIT = 14;
    localparam int SH_LSB    = 18;
    localparam int PG_SHIFT  = 12;

    localparam logic [2:0] DM_FIXED = 3'b000;
    localparam logic [2:0] DM_NMI   = 3'b100;
    localparam logic [2:0] DM_INIT  = 3'b101;
    localparam logic [2:0] DM_START = 3'b110;

    localparam logic [1:0] SH_EXPL  = 2'b00;
    localparam logic [1:0] SH_SELF  = 2'b01;
    localparam logic [1:0] SH_ALL   = 2'b10;
    localparam logic [1:0] SH_OTHER = 2'b11;

    typedef enum logic [1:0] {
        BOOT_HELD = 2'd0,
        BOOT_WAIT = 2'd1,
        BOOT_RUN  = 2'd2
    } boot_e;

    typedef struct packed {
        logic [7:0]  vec;
        logic [2:0]  mode;
        logic        level;
        logic [1:0]  shorthand;
        logic [31:0] dest;
    } cmd_fields_t;

endpackage

// File: rtl/ipi_cmd_decode.sv
// Module: ipi_cmd_decode
// Holds the legacy high half and splits the effective command into fields.
// Assumes hi_wr and send are not raised together; field layout from package.
module ipi_cmd_decode
    import ipi_seq_pkg::*;
#(
    parameter int NPROC = 8,
    localparam int IDXW = $clog2(NPROC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_wr,
    input  logic              x2_mode,
    input  logic [63:0]       cmd_word,
    output cmd_fields_t       fields,
    output logic              dest_ok,
    output logic              dest_nz,
    output logic [IDXW-1:0]   dest_idx
);

    logic [31:0] hi_q;
    logic [63:0] eff_word;

    // Store the high half on a legacy-mode high write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
        end else if (hi_wr && !x2_mode) begin
            hi_q <= cmd_word[63:32];
        end
    end

    // Build the effective word and pull out each field.
    always_comb begin
        eff_word         = x2_mode ? cmd_word : {hi_q, cmd_word[31:0]};
        fields.vec       = eff_word[VEC_LSB +: 8];
        fields.mode      = eff_word[MODE_LSB +: 3];
        fields.level     = eff_word[LEVEL_BIT];
        fields.shorthand = eff_word[SH_LSB +: 2];
        fields.dest      = x2_mode ? eff_word[63:32] : {24'd0, eff_word[63:56]};
        dest_ok          = fields.dest < 32'(NPROC);
        dest_nz          = fields.dest != 32'd0;
        dest_idx         = fields.dest[IDXW-1:0];
    end

endmodule

// File: rtl/ipi_fanout.sv
// Module: ipi_fanout
// Turns the destination shorthand into a per-processor target set.
// Assumes sender < NPROC; explicit destinations out of range give no target.
module ipi_fanout
    import ipi_seq_pkg::*;
#(
    parameter int NPROC = 8,
    localparam int IDXW = $clog2(NPROC)
) (
    input  logic [1:0]       shorthand,
    input  logic             dest_ok,
    input  logic [IDXW-1:0]  dest_idx,
    input  logic [IDXW-1:0]  sender,
    input  logic [NPROC-1:0] active_set,
    output logic [NPROC-1:0] tset
);

    for (genvar i = 0; i < NPROC; i++) begin : g_tgt
        // Decide whether processor i belongs to the target set.
        always_comb begin
            unique case (shorthand)
                SH_EXPL:  tset[i] = dest_ok && (dest_idx == IDXW'(i));
                SH_SELF:  tset[i] = (sender == IDXW'(i));
                SH_ALL:   tset[i] = active_set[i];
                default:  tset[i] = active_set[i] && (sender != IDXW'(i));
            endcase
        end
    end

endmodule

// File: rtl/ipi_boot_ctrl.sv
// Module: ipi_boot_ctrl
// Per-processor boot state: held -> waiting -> running.
// Assumes the callers have already qualified sender and destination.
module ipi_boot_ctrl
    import ipi_seq_pkg::*;
#(
    parameter int NPROC = 8,
    localparam int IDXW = $clog2(NPROC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_go,
    input  logic             start_go,
    input  logic [IDXW-1:0]  tgt_idx,
    output logic [NPROC-1:0] wait_mask,
    output logic [NPROC-1:0] run_mask
);

    for (genvar i = 0; i < NPROC; i++) begin : g_proc
        localparam boot_e RST_ST = (i == 0) ? BOOT_RUN : BOOT_HELD;
        boot_e st_q;
        logic  hit;

        assign hit = (tgt_idx == IDXW'(i));

        // Advance this processor's boot state on a qualified command.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q <= RST_ST;
            end else if (init_go && hit && st_q == BOOT_HELD) begin
                st_q <= BOOT_WAIT;
            end else if (start_go && hit && st_q == BOOT_WAIT) begin
                st_q <= BOOT_RUN;
            end
        end

        assign wait_mask[i] = (st_q == BOOT_WAIT);
        assign run_mask[i]  = (st_q == BOOT_RUN);
    end

endmodule

// File: rtl/ipi_startup_seq.sv
// Module: ipi_startup_seq (top)
// Decodes an interprocessor command, fans fixed/NMI deliveries out to a
// target set and runs the INIT/startup boot handshake. Outputs are
// registered one cycle after send. Assumes send and hi_wr are exclusive.
module ipi_startup_seq
    import ipi_seq_pkg::*;
#(
    parameter int NPROC = 8,
    localparam int IDXW  = $clog2(NPROC),
    localparam int ADDRW = 8 + PG_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [63:0]      cmd_word,
    input  logic             send,
    input  logic             hi_wr,
    input  logic [IDXW-1:0]  sender,
    input  logic             x2_mode,
    input  logic [NPROC-1:0] active_mask,
    output logic [NPROC-1:0] intr_stb,
    output logic [7:0]       intr_vec,
    output logic [NPROC-1:0] nmi_stb,
    output logic             start_vld,
    output logic [IDXW-1:0]  start_tgt,
    output logic [ADDRW-1:0] start_addr,
    output logic             unhandled
);

    cmd_fields_t      f;
    logic             dest_ok, dest_nz;
    logic [IDXW-1:0]  dest_idx;
    logic [NPROC-1:0] tset, wait_mask, run_mask, active_set;
    logic             is_fixed, is_nmi, is_init, is_start;
    logic             boot_ok, init_drop, init_go, start_go, handled;

    ipi_cmd_decode #(.NPROC(NPROC)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .hi_wr    (hi_wr),
        .x2_mode  (x2_mode),
        .cmd_word (cmd_word),
        .fields   (f),
        .dest_ok  (dest_ok),
        .dest_nz  (dest_nz),
        .dest_idx (dest_idx)
    );

    assign active_set = active_mask | run_mask;

    ipi_fanout #(.NPROC(NPROC)) u_fan (
        .shorthand  (f.shorthand),
        .dest_ok    (dest_ok),
        .dest_idx   (dest_idx),
        .sender     (sender),
        .active_set (active_set),
        .tset       (tset)
    );

    // Classify the command and qualify the boot handshake.
    always_comb begin
        is_fixed  = (f.mode == DM_FIXED);
        is_nmi    = (f.mode == DM_NMI);
        is_init   = (f.mode == DM_INIT);
        is_start  = (f.mode == DM_START);
        boot_ok   = (sender == '0) && dest_ok && dest_nz;
        init_drop = is_init && !f.level;
        init_go   = send && is_init && f.level && boot_ok;
        start_go  = send && is_start && boot_ok && wait_mask[dest_idx];
        handled   = is_fixed || is_nmi || init_drop
                    || (is_init && boot_ok) || (is_start && boot_ok);
    end

    ipi_boot_ctrl #(.NPROC(NPROC)) u_boot (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_go   (init_go),
        .start_go  (start_go),
        .tgt_idx   (dest_idx),
        .wait_mask (wait_mask),
        .run_mask  (run_mask)
    );

    // Register the delivery strobes and startup request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            intr_stb   <= '0;
            intr_vec   <= '0;
            nmi_stb    <= '0;
            start_vld  <= 1'b0;
            start_tgt  <= '0;
            start_addr <= '0;
            unhandled  <= 1'b0;
        end else begin
            intr_stb   <= (send && is_fixed) ? tset : '0;
            intr_vec   <= (send && is_fixed) ? f.vec : '0;
            nmi_stb    <= (send && is_nmi) ? tset : '0;
            start_vld  <= start_go;
            start_tgt  <= start_go ? dest_idx : '0;
            start_addr <= start_go ? {f.vec, {PG_SHIFT{1'b0}}} : '0;
            unhandled  <= send && !handled;
        end
    end

endmodule

// File: rtl/ipi_startup_seq_chk.sv
// Module: ipi_startup_seq_chk
// Assertion checker bound to ipi_startup_seq. Assumes sender < NPROC on send.
module ipi_startup_seq_chk #(
    parameter int NPROC = 8,
    localparam int IDXW = $clog2(NPROC)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [63:0]      cmd_word,
    input logic             send,
    input logic [IDXW-1:0]  sender,
    input logic [NPROC-1:0] intr_stb,
    input logic [NPROC-1:0] nmi_stb,
    input logic             start_vld,
    input logic [IDXW-1:0]  start_tgt,
    input logic             unhandled
);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !send |=> (intr_stb == '0 && nmi_stb == '0 && !start_vld && !unhandled));

    p_one_kind_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({|intr_stb, |nmi_stb, start_vld, unhandled}));

    p_start_tgt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_vld |-> (start_tgt != '0));

    p_self_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (send && cmd_word[10:8] == 3'b000 && cmd_word[19:18] == 2'b01)
        |=> (intr_stb == (NPROC'(1) << $past(sender))));

    p_excl_sender_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (send && cmd_word[10:8] == 3'b100 && cmd_word[19:18] == 2'b11)
        |=> !nmi_stb[$past(sender)]);

    p_foreign_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (send && cmd_word[10:8] == 3'b110 && sender != '0) |=> unhandled);

    p_deassert_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (send && cmd_word[10:8] == 3'b101 && !cmd_word[14])
        |=> (!unhandled && !start_vld));

endmodule

bind ipi_startup_seq ipi_startup_seq_chk #(.NPROC(NPROC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_word  (cmd_word),
    .send      (send),
    .sender    (sender),
    .intr_stb  (intr_stb),
    .nmi_stb   (nmi_stb),
    .start_vld (start_vld),
    .start_tgt (start_tgt),
    .unhandled (unhandled)
);

// File: tb/tb_ipi_startup_seq.sv
module tb_ipi_startup_seq;

    localparam int NPROC = 8;
    localparam int IDXW  = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [63:0]      cmd_word = '0;
    logic             send = 1'b0;
    logic             hi_wr = 1'b0;
    logic [IDXW-1:0]  sender = '0;
    logic             x2_mode = 1'b0;
    logic [NPROC-1:0] active_mask = '0;
    logic [NPROC-1:0] intr_stb, nmi_stb;
    logic [7:0]       intr_vec;
    logic             start_vld, unhandled;
    logic [IDXW-1:0]  start_tgt;
    logic [19:0]      start_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ipi_startup_seq #(.NPROC(NPROC)) dut (.*);

    task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Low half: shorthand, level, mode, vector (R2 layout).
    function automatic logic [31:0] lo(logic [1:0] sh, logic lvl, logic [2:0] md, logic [7:0] v);
        return {12'd0, sh, 3'd0, lvl, 3'd0, md, v};
    endfunction

    task automatic wr_hi(logic [7:0] dest);
        @(negedge clk);
        cmd_word = {dest, 24'd0, 32'hDEAD_BEEF};
        hi_wr = 1'b1;
        @(negedge clk);
        hi_wr = 1'b0;
    endtask

    // Send and sample at the next falling edge (outputs registered once).
    task automatic issue(logic [63:0] w, logic [IDXW-1:0] s);
        @(negedge clk);
        cmd_word = w;
        sender = s;
        send = 1'b1;
        @(negedge clk);
        send = 1'b0;
    endtask

    task automatic expect_out(string tag, logic [7:0] ei, logic [7:0] ev,
                              logic [7:0] en, logic es, logic [2:0] et,
                              logic [19:0] ea, logic eu);
        chk({tag, " intr_stb"}, 64'(intr_stb), 64'(ei));
        chk({tag, " intr_vec"}, 64'(intr_vec), 64'(ev));
        chk({tag, " nmi_stb"}, 64'(nmi_stb), 64'(en));
        chk({tag, " start_vld"}, 64'(start_vld), 64'(es));
        chk({tag, " start_tgt"}, 64'(start_tgt), 64'(et));
        chk({tag, " start_addr"}, 64'(start_addr), 64'(ea));
        chk({tag, " unhandled"}, 64'(unhandled), 64'(eu));
    endtask

    task automatic t_reset;
        expect_out("R1 reset", 0, 0, 0, 0, 0, 0, 0);
        // Startup to held processor 3: ignored, not unhandled (R1, R9).
        wr_hi(8'd3);
        expect_out("R3 hi write only", 0, 0, 0, 0, 0, 0, 0);
        issue({32'hFFFF_FFFF, lo(2'b00, 1, 3'b110, 8'h20)}, 0);
        expect_out("R9 start held", 0, 0, 0, 0, 0, 0, 0);
        // All-including with empty mask: only processor 0 (R1, R6).
        issue({32'h0, lo(2'b10, 1, 3'b000, 8'h33)}, 0);
        expect_out("R1 active set", 8'h01, 8'h33, 0, 0, 0, 0, 0);
    endtask

    task automatic t_fixed_legacy;
        wr_hi(8'd5);
        issue({32'h0200_0000, lo(2'b00, 0, 3'b000, 8'h41)}, 1);
        expect_out("R3 R4 legacy fixed", 8'h20, 8'h41, 0, 0, 0, 0, 0);
        issue({32'h0, 32'h0}, 0);
        @(negedge clk);
        expect_out("R11 idle", 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_x2;
        x2_mode = 1'b1;
        issue({32'd6, lo(2'b00, 0, 3'b000, 8'h55)}, 2);
        expect_out("R2 x2 dest", 8'h40, 8'h55, 0, 0, 0, 0, 0);
        issue({32'd40, lo(2'b00, 0, 3'b000, 8'h55)}, 2);
        expect_out("R6 out of range", 0, 8'h55, 0, 0, 0, 0, 0);
        wr_hi(8'd2);                       // ignored in x2 mode (R3)
        x2_mode = 1'b0;
        issue({32'h0700_0000, lo(2'b00, 0, 3'b000, 8'h66)}, 1);
        expect_out("R3 x2 hi write ignored", 8'h20, 8'h66, 0, 0, 0, 0, 0);
    endtask

    task automatic t_nmi_shorthand;
        issue({32'h0, lo(2'b01, 0, 3'b100, 8'h00)}, 2);
        expect_out("R5 nmi self", 0, 0, 8'h04, 0, 0, 0, 0);
        active_mask = 8'hA6;
        issue({32'h0, lo(2'b11, 0, 3'b000, 8'h70)}, 0);
        expect_out("R6 all excl", 8'hA6, 8'h70, 0, 0, 0, 0, 0);
        issue({32'h0, lo(2'b11, 0, 3'b100, 8'h00)}, 5);
        expect_out("R5 R6 nmi excl", 0, 0, 8'h87, 0, 0, 0, 0);
        active_mask = 8'h00;
    endtask

    task automatic t_boot;
        wr_hi(8'd3);
        issue({32'h0, lo(2'b00, 0, 3'b101, 8'h00)}, 0);
        expect_out("R7 init deassert", 0, 0, 0, 0, 0, 0, 0);
        issue({32'h0, lo(2'b00, 0, 3'b110, 8'h12)}, 0);
        expect_out("R7 no state change", 0, 0, 0, 0, 0, 0, 0);
        issue({32'h0, lo(2'b00, 0, 3'b101, 8'h00)}, 4);
        expect_out("R7 deassert foreign", 0, 0, 0, 0, 0, 0, 0);
        issue({32'h0, lo(2'b00, 1, 3'b101, 8'h00)}, 0);
        expect_out("R8 init", 0, 0, 0, 0, 0, 0, 0);
        issue({32'h0, lo(2'b00, 1, 3'b110, 8'h9A)}, 0);
        expect_out("R9 startup", 0, 0, 0, 1, 3'd3, 20'h9A000, 0);
        issue({32'h0, lo(2'b00, 1, 3'b110, 8'h9B)}, 0);
        expect_out("R9 second startup", 0, 0, 0, 0, 0, 0, 0);
        issue({32'h0, lo(2'b00, 1, 3'b101, 8'h00)}, 0);
        issue({32'h0, lo(2'b00, 1, 3'b110, 8'h9C)}, 0);
        expect_out("R8 running unchanged", 0, 0, 0, 0, 0, 0, 0);
        issue({32'h0, lo(2'b10, 0, 3'b000, 8'h21)}, 0);
        expect_out("R9 now active", 8'h09, 8'h21, 0, 0, 0, 0, 0);
    endtask

    task automatic t_unhandled;
        wr_hi(8'd4);
        issue({32'h0, lo(2'b00, 1, 3'b101, 8'h00)}, 2);
        expect_out("R10 foreign init", 0, 0, 0, 0, 0, 0, 1);
        issue({32'h0, lo(2'b00, 1, 3'b010, 8'h00)}, 0);
        expect_out("R10 other mode", 0, 0, 0, 0, 0, 0, 1);
        wr_hi(8'd0);
        issue({32'h0, lo(2'b00, 1, 3'b110, 8'h10)}, 0);
        expect_out("R10 start dest0", 0, 0, 0, 0, 0, 0, 1);
        x2_mode = 1'b1;
        issue({32'd9, lo(2'b00, 1, 3'b110, 8'h10)}, 0);
        expect_out("R10 start dest range", 0, 0, 0, 0, 0, 0, 1);
        x2_mode = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fixed_legacy();
        t_x2();
        t_nmi_shorthand();
        t_boot();
        t_unhandled();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule